// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Translator

This block sits between an on-chip bus and up to four serial NOR flash devices. Each flash has its own address window, chosen by the top bits of the bus address. A byte read inside a window turns into a flash read command. A byte write turns into a page-program command. The block runs only when the controller is in hardware mode. Surrounding logic supplies the mode bits, the bank enables and the per-bank write-permission flags as plain inputs.

The serial side uses mode 0 framing, most significant bit first. The clock is low while idle, and data changes while the clock is low and is taken on its rising edge. Each serial bit takes two core clocks.

In burst mode, a write that continues at the next address of the same bank keeps chip select low and sends only the new data byte. The burst ends on any other access or when burst mode is switched off. Ending a write transaction pulses a write-done flag, which can also raise an interrupt, and asks for that bank's write permission to be withdrawn. The bus is held off until the serial work for the current access has finished.

Top module: `sflash_xlat`

## Requirements
- R1: While `sw_mode` is high, any bus access is refused. `bad_acc` pulses together with a one-cycle `bus_ready`, read data is 0, and no chip select goes low.
- R2: An access to a bank whose `bank_en` bit is low is refused in the same way as R1.
- R3: The bank is `bus_addr[25:24]`, and only that bank's `cs_n` bit goes low. `sck` pulses only while a chip select is low.
- R4: With `fast_rd` low, a read sends 0x03, then the three offset bytes (high byte first), then one filler byte of 0x00 while capturing the flash's byte. The captured byte is returned on `bus_rdata`.
- R5: With `fast_rd` high, a read sends 0x0B, the three offset bytes, one 0x00 dummy byte, and then one 0x00 filler byte while capturing the returned byte.
- R6: A write to a bank whose `wm_flag` bit is low is dropped. `bad_wr` pulses with `bus_ready`, and no chip select goes low.
- R7: With burst mode off, a permitted write sends 0x02, the three offset bytes and the data byte. Chip select then rises, `wr_done` pulses, and the `wm_clr` bit of that bank pulses.
- R8: With `burst_en` high, each following write to the same bank at the next offset keeps chip select low and sends only its data byte, with no new opcode or address.
- R9: An open burst is ended by clearing `burst_en`, by a read, or by a write that is not consecutive. Ending it raises chip select and pulses `wr_done` and `wm_clr`. A write that ended the burst is then judged with the bank's permission already withdrawn, so it is refused as in R6.
- R10: `irq` equals `wr_done` gated by `wc_ie`.
- R11: `bus_ready` is a one-cycle pulse that comes only after the last serial bit of the access. `bus_rdata` is valid with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| sw_mode | input | 1 | Software mode active; refuses bus accesses |
| fast_rd | input | 1 | Use fast read command for reads |
| burst_en | input | 1 | Stream consecutive writes into one program command |
| wc_ie | input | 1 | Interrupt enable for write done |
| bank_en | input | 4 | Per-bank enable |
| wm_flag | input | 4 | Per-bank write permission |
| bus_req | input | 1 | Access request, held until ready |
| bus_we | input | 1 | Access is a write |
| bus_addr | input | 26 | Bank number in top bits, flash offset below |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte |
| bus_ready | output | 1 | Access complete |
| wm_clr | output | 4 | Withdraw write permission of a bank |
| wr_done | output | 1 | Write transaction finished |
| irq | output | 1 | Write-done interrupt |
| bad_wr | output | 1 | Forbidden write pulse |
| bad_acc | output | 1 | Forbidden access pulse |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to flash |
| cs_n | output | 4 | Active-low chip selects, one per bank |
| miso | input | 1 | Serial data from flash |

## Verification
The bench builds the block with its defaults: four banks and 24-bit offsets. With these values, every bank window and both chip-select extremes (banks 0 and 3) can be reached from the bench, and the full three-byte address is visible on the wire. A behavioural flash model in the bench decodes every byte shifted out and returns a chosen byte. This lets the bench compare exact command, address and data sequences, including bursts that end in each of the three ways. Offsets are picked with distinct high, middle and low bytes, so that address bytes out of order would show up.

// File: rtl/sflash_xlat.sv
module sflash_xlat #(
  parameter int BANKS = 4,
  parameter int OFS_W = 24,
  parameter int AW = OFS_W + $clog2(BANKS),
  parameter logic [7:0] OP_RD = 8'h03,
  parameter logic [7:0] OP_FRD = 8'h0B,
  parameter logic [7:0] OP_PP = 8'h02
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_mode,
  input  logic             fast_rd,
  input  logic             burst_en,
  input  logic             wc_ie,
  input  logic [BANKS-1:0] bank_en,
  input  logic [BANKS-1:0] wm_flag,
  input  logic             bus_req,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  output logic             bus_ready,
  output logic [BANKS-1:0] wm_clr,
  output logic             wr_done,
  output logic             irq,
  output logic             bad_wr,
  output logic             bad_acc,
  output logic             sck,
  output logic             mosi,
  output logic [BANKS-1:0] cs_n,
  input  logic             miso
);
  localparam int BW = $clog2(BANKS);
  localparam int AB = OFS_W / 8;
  localparam int IW = $clog2(AB + 3);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_HOLD, S_END} st_t;

  st_t            st;
  logic [BW-1:0]  bk;
  logic [OFS_W-1:0] ofs, nxt;
  logic           wr, ph;
  logic [IW-1:0]  bidx, blast;
  logic [2:0]     bit_i;
  logic [7:0]     sh, wd;

  wire [BW-1:0]    req_bk  = bus_addr[AW-1 -: BW];
  wire [OFS_W-1:0] req_ofs = bus_addr[OFS_W-1:0];
  wire [BANKS-1:0] wm_eff  = wm_flag & ~wm_clr;
  wire pending    = bus_req && !bus_ready;
  wire take       = pending && (st == S_IDLE);
  wire refuse_acc = sw_mode || !bank_en[req_bk];
  wire refuse_wr  = bus_we && !wm_eff[req_bk];
  wire chain      = pending && burst_en && bus_we && (req_bk == bk) &&
                    (req_ofs == nxt) && !refuse_acc && wm_eff[req_bk];

  function automatic logic [7:0] next_byte(input logic [IW-1:0] k);
    if (k <= IW'(AB))
      return 8'(ofs >> (8 * (AB - int'(k))));
    return wr ? wd : 8'h00;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      bk <= '0; ofs <= '0; nxt <= '0; wr <= 1'b0; ph <= 1'b0;
      bidx <= '0; blast <= '0; bit_i <= '0; sh <= '0; wd <= '0;
      bus_rdata <= '0; bus_ready <= 1'b0; wm_clr <= '0;
      wr_done <= 1'b0; bad_wr <= 1'b0; bad_acc <= 1'b0;
    end else begin
      bus_ready <= 1'b0;
      bad_acc   <= 1'b0;
      bad_wr    <= 1'b0;
      wr_done   <= 1'b0;
      wm_clr    <= '0;
      case (st)
        S_IDLE: if (take) begin
          if (refuse_acc) begin
            bad_acc   <= 1'b1;
            bus_ready <= 1'b1;
            bus_rdata <= '0;
          end else if (refuse_wr) begin
            bad_wr    <= 1'b1;
            bus_ready <= 1'b1;
          end else begin
            st    <= S_SHIFT;
            bk    <= req_bk;
            ofs   <= req_ofs;
            wr    <= bus_we;
            wd    <= bus_wdata;
            bidx  <= '0;
            bit_i <= '0;
            ph    <= 1'b0;
            sh    <= bus_we ? OP_PP : (fast_rd ? OP_FRD : OP_RD);
            blast <= (!bus_we && fast_rd) ? IW'(AB + 2) : IW'(AB + 1);
          end
        end
        S_SHIFT: begin
          if (!ph) begin
            ph <= 1'b1;
          end else begin
            ph    <= 1'b0;
            bit_i <= bit_i + 3'd1;
            sh    <= {sh[6:0], miso};
            if (bit_i == 3'd7) begin
              if (bidx == blast) begin
                bus_ready <= 1'b1;
                if (!wr) begin
                  bus_rdata <= {sh[6:0], miso};
                  st <= S_END;
                end else begin
                  nxt <= ofs + 1'b1;
                  st  <= burst_en ? S_HOLD : S_END;
                end
              end else begin
                bidx <= bidx + 1'b1;
                sh   <= next_byte(bidx + 1'b1);
              end
            end
          end
        end
        S_HOLD: begin
          if (!burst_en) begin
            st <= S_END;
          end else if (pending) begin
            if (chain) begin
              st    <= S_SHIFT;
              ofs   <= req_ofs;
              wd    <= bus_wdata;
              sh    <= bus_wdata;
              bidx  <= blast;
              bit_i <= '0;
              ph    <= 1'b0;
            end else begin
              st <= S_END;
            end
          end
        end
        default: begin
          st <= S_IDLE;
          if (wr) begin
            wr_done <= 1'b1;
            wm_clr  <= BANKS'(1) << bk;
          end
        end
      endcase
    end
  end

  assign sck  = ph;
  assign mosi = (st == S_SHIFT) ? sh[7] : 1'b0;
  assign cs_n = (st == S_SHIFT || st == S_HOLD) ? ~(BANKS'(1) << bk) : '1;
  assign irq  = wr_done && wc_ie;

  a_r1_sw_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (take && sw_mode) |=> (bad_acc && bus_ready && (&cs_n)));

  a_r3_sck_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> !(&cs_n));

  a_r6_wr_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !sw_mode && bank_en[req_bk] && bus_we && !wm_eff[req_bk]) |=> (bad_wr && (&cs_n)));

  a_r9_clr_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    (|wm_clr) |-> (wr_done && $countones(wm_clr) == 1));

  a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (wc_ie && wr_done));

  a_r11_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |=> !bus_ready);
endmodule

// File: tb/sflash_xlat_tb_top.sv
module sflash_xlat_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, sw_mode, fast_rd, burst_en, wc_ie;
  logic [3:0] bank_en, wm;
  logic bus_req, bus_we;
  logic [25:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic bus_ready, wr_done, irq, bad_wr, bad_acc, sck, mosi;
  logic [3:0] wm_clr, cs_n;
  logic miso = 1'b0;

  sflash_xlat dut_i (
    .clk(clk), .rst_n(rst_n), .sw_mode(sw_mode), .fast_rd(fast_rd),
    .burst_en(burst_en), .wc_ie(wc_ie), .bank_en(bank_en), .wm_flag(wm),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .wm_clr(wm_clr), .wr_done(wr_done), .irq(irq), .bad_wr(bad_wr),
    .bad_acc(bad_acc), .sck(sck), .mosi(mosi), .cs_n(cs_n), .miso(miso));

  int checks = 0, fails = 0;
  int n_acc, n_wr, n_done, n_irq, nb;
  logic [7:0] cap[$];
  logic [7:0] cur, resp;
  logic [3:0] lowmask;

  always @(negedge clk) begin
    if (rst_n) begin
      n_acc  += int'(bad_acc);
      n_wr   += int'(bad_wr);
      n_done += int'(wr_done);
      n_irq  += int'(irq);
      wm = wm & ~wm_clr;
      lowmask |= ~cs_n;
      if (&cs_n) nb = 0;
      else if (sck) begin
        cur = {cur[6:0], mosi};
        miso = resp[7 - (nb % 8)];
        nb++;
        if (nb % 8 == 0) cap.push_back(cur);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_bytes(input string tag, input logic [7:0] e[$]);
    chk(cap.size() == e.size(), {tag, " byte count"}, cap.size(), e.size());
    for (int i = 0; i < e.size() && i < cap.size(); i++)
      chk(cap[i] == e[i], {tag, " byte"}, cap[i], e[i]);
  endtask

  task automatic clr();
    n_acc = 0; n_wr = 0; n_done = 0; n_irq = 0; cap.delete(); lowmask = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic access(input bit we, input int bank, input int ofs,
                        input logic [7:0] d, output logic [7:0] rd, output int ncap);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we;
    bus_addr = {bank[1:0], ofs[23:0]}; bus_wdata = d;
    do @(negedge clk); while (!bus_ready);
    rd = bus_rdata; ncap = cap.size();
    bus_req = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int nc;
    rst_n = 1'b0; sw_mode = 0; fast_rd = 0; burst_en = 0; wc_ie = 1;
    bank_en = 4'hF; wm = 4'h0; bus_req = 0; bus_we = 0; bus_addr = '0;
    bus_wdata = '0; resp = 8'h00; cur = '0; nb = 0; clr();
    idle(3);
    chk(cs_n == 4'hF && !sck && !bus_ready, "R11 reset state", {cs_n, sck, bus_ready}, 8'hF0 >> 2);
    rst_n = 1'b1;
    idle(2);

    clr(); resp = 8'hA5;
    access(0, 0, 24'h123456, 8'h00, rd, nc);
    idle(3);
    chk(rd == 8'hA5, "R4 read data", rd, 8'hA5);
    chk_bytes("R4 normal read frame", '{8'h03, 8'h12, 8'h34, 8'h56, 8'h00});
    chk(nc == 5, "R11 ready after last bit", nc, 5);
    chk(lowmask == 4'b0001, "R3 bank0 select", lowmask, 1);

    clr(); resp = 8'h3C; fast_rd = 1;
    access(0, 3, 24'h00ABCD, 8'h00, rd, nc);
    idle(3); fast_rd = 0;
    chk(rd == 8'h3C, "R5 fast read data", rd, 8'h3C);
    chk_bytes("R5 fast read frame", '{8'h0B, 8'h00, 8'hAB, 8'hCD, 8'h00, 8'h00});
    chk(lowmask == 4'b1000, "R3 bank3 select", lowmask, 8);

    clr(); sw_mode = 1;
    access(0, 2, 24'h000100, 8'h00, rd, nc);
    idle(3); sw_mode = 0;
    chk(n_acc == 1 && rd == 8'h00, "R1 sw mode refused", n_acc, 1);
    chk(lowmask == 4'b0000 && cap.size() == 0, "R1 no select", lowmask, 0);

    clr(); bank_en = 4'b1101;
    access(0, 1, 24'h000200, 8'h00, rd, nc);
    idle(3); bank_en = 4'hF;
    chk(n_acc == 1 && lowmask == 0, "R2 disabled bank refused", n_acc, 1);

    clr(); wm = 4'b0000;
    access(1, 3, 24'h000300, 8'h99, rd, nc);
    idle(3);
    chk(n_wr == 1 && lowmask == 0 && cap.size() == 0, "R6 write dropped", n_wr, 1);

    clr(); wm = 4'b0010; wc_ie = 1;
    access(1, 1, 24'h00C0DE, 8'h5A, rd, nc);
    idle(4);
    chk_bytes("R7 single program frame", '{8'h02, 8'h00, 8'hC0, 8'hDE, 8'h5A});
    chk(n_done == 1 && wm == 4'b0000, "R7 done and flag withdrawn", {n_done[3:0], wm}, 8'h10);
    chk(n_irq == 1, "R10 irq with enable", n_irq, 1);

    clr(); wm = 4'b0001; burst_en = 1;
    access(1, 0, 24'h000010, 8'h11, rd, nc);
    access(1, 0, 24'h000011, 8'h22, rd, nc);
    access(1, 0, 24'h000012, 8'h33, rd, nc);
    access(1, 0, 24'h000013, 8'h44, rd, nc);
    idle(2);
    chk(cs_n[0] == 1'b0 && n_done == 0, "R8 burst keeps select", {cs_n, n_done[3:0]}, 8'hE0);
    burst_en = 0;
    idle(4);
    chk_bytes("R8 burst frame", '{8'h02, 8'h00, 8'h00, 8'h10, 8'h11, 8'h22, 8'h33, 8'h44});
    chk(cs_n == 4'hF && n_done == 1 && wm == 0, "R9 burst off ends", {cs_n, n_done[3:0]}, 8'hF1);

    clr(); wm = 4'b0100; burst_en = 1; wc_ie = 0;
    access(1, 2, 24'h000020, 8'hD1, rd, nc);
    access(1, 2, 24'h000040, 8'hD2, rd, nc);
    idle(4);
    chk_bytes("R9 gap ends burst", '{8'h02, 8'h00, 8'h00, 8'h20, 8'hD1});
    chk(n_done == 1 && n_wr == 1, "R9 gap write refused", {n_done[3:0], n_wr[3:0]}, 8'h11);
    chk(n_irq == 0, "R10 irq masked", n_irq, 0);

    clr(); wm = 4'b0010; wc_ie = 1; resp = 8'h77;
    access(1, 1, 24'h000050, 8'hE0, rd, nc);
    access(0, 1, 24'h000051, 8'h00, rd, nc);
    idle(4); burst_en = 0;
    chk(rd == 8'h77, "R9 read after burst data", rd, 8'h77);
    chk_bytes("R9 read ends burst", '{8'h02, 8'h00, 8'h00, 8'h50, 8'hE0,
                                      8'h03, 8'h00, 8'h00, 8'h51, 8'h00});
    chk(n_done == 1 && n_irq == 1, "R10 irq after read end", {n_done[3:0], n_irq[3:0]}, 8'h11);

    summary();
    $finish;
  end
endmodule